// File: doc/BRIEF.md
# Read-Triggered Clocked Serial Receiver (Master)

This block is the receive half of a clocked serial master. It drives the serial clock itself and shifts in bytes from one data input. It moves no data on its own initiative. Each byte transfer is started by a host read of the receive data register while reception is enabled. The very first read of a session is a dummy read whose only purpose is to start the clocks. Each later read returns the byte that has arrived and also starts the next one.

The host reaches the block through a plain synchronous register bus. The bus has a 2-bit address, read and write strobes, write data, and read data that is registered one cycle after the read strobe. The received-data path is deliberately not a valid/ready stream. Back-pressure is expressed through the full flag. A byte that completes while the previous byte is still unread is dropped, the overrun flag is raised, and the overrun flag blocks every further transfer until software clears it.

Software ends a session in one of two ways:
- **Stop request.** Software sets the stop bit while the final byte is in flight. That byte completes, and later data reads produce no clocks.
- **Disable and read.** Software clears both the enable bit and the stop bit, then reads the last byte without starting another transfer.

Register map (address: content):
- **0, control:** bit0 = enable, bit1 = stop.
- **1, status:** bit0 = full, bit1 = overrun.
- **2, receive data.**
- **3, clock divider.**

Top module: `sync_rx_master`

## Requirements
- R1: After reset: control reads 0, status reads 0, the divider reads its reset value (3), and `ser_clk` is 1.
- R2: With enable = 0, a read of address 2 returns data but generates no serial clock edges.
- R3: Bit sampling and serial clock:
  - Bits are sampled on the rising edge of `ser_clk`, most significant bit first.
  - `ser_clk` idles high between bytes.
  - Each half-period of `ser_clk` lasts divider+1 clock cycles, starting with a low half at the edge that accepts the triggering read.
- R4: The full flag (status bit0) becomes 1 one cycle after the eighth rising edge of `ser_clk`. That is 15·(divider+1)+1 cycles after the clock edge that accepted the triggering read.
- R5: A read of address 2 returns the stored byte and clears the full flag.
- R6: Continuous reception and queuing:
  - With enable = 1, stop = 0 and no overrun, each read of address 2 made while idle starts a new byte.
  - A read made while a byte is in flight queues exactly one further byte. That byte starts as soon as the current one ends.
- R7: While stop = 1, the byte in flight completes and is stored, but reads of address 2 start no further transfer.
- R8: After software writes control = 0, a read of address 2 returns the last byte, starts no clocks, and leaves status at 0.
- R9: Overrun:
  - If a byte completes while full = 1 and the same cycle has no data read, the overrun flag (status bit1) is set.
  - The new byte is discarded and the stored byte is kept.
- R10: While overrun = 1, reads of address 2 start no transfer.
- R11: Clearing overrun:
  - Writing status with bit1 = 0 clears the overrun flag only if a status read returned overrun = 1 after the flag was set.
  - Writing bit1 = 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_din | input | 1 | Serial data input, sampled on rising `ser_clk` |

## Verification
The bench drives every strobe at a falling clock edge and counts the accepting rising edges.

- **Read latency.** Read data is compared one cycle after the read strobe.
- **Full-flag timing (R4).** A status read is accepted exactly 15·(divider+1)+1 cycles after the triggering read and must still show full = 0. The very next status read must show full = 1. This pins down both the half-period and the one-cycle flag delay.
- **Serial data.** The serial data line is changed on each falling `ser_clk` edge, so every bit is stable long before its sampling edge.
- **Blocked transfers (R2, R7, R8, R10).** These are checked by counting falling `ser_clk` edges over a window of 60 cycles after the read that must not trigger.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2,
    RA_DIV  = 2'd3
  } rxm_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_STOP_BIT = 1;
  localparam int STAT_FULL_BIT = 0;
  localparam int STAT_OVR_BIT  = 1;
endpackage

// File: rtl/rxm_shifter.sv
module rxm_shifter #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [DIVW-1:0] div,
  input  logic            sdi,
  output logic            sck,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   byte_o
);
  localparam int NBW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [NBW-1:0] LAST_BIT = NBW'(DW - 1);

  logic [DIVW-1:0] cnt;
  logic [NBW-1:0]  nbit;
  logic [DW-1:0]   shreg;

  assign byte_o = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck   <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      nbit  <= '0;
      shreg <= '0;
    end else begin
      done <= 1'b0;
      if (launch && !busy) begin
        busy <= 1'b1;
        sck  <= 1'b0;
        cnt  <= '0;
        nbit <= '0;
      end else if (busy) begin
        if (cnt == div) begin
          cnt <= '0;
          sck <= ~sck;
          if (!sck) begin
            shreg <= {shreg[DW-2:0], sdi};
            nbit  <= nbit + 1'b1;
            if (nbit == LAST_BIT) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxm_regs.sv
module rxm_regs
  import rxm_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DIVW    = 8,
  parameter int DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DW-1:0]     byte_i,
  output logic              launch,
  output logic [DIVW-1:0]   div
);
  logic          en_q, stop_q, full_q, ovr_q, armed_q, pend_q;
  logic [DW-1:0] data_q;
  logic          rd_data, rd_stat, wr_stat, ok_go;

  assign rd_data = rd && (addr == RA_DATA);
  assign rd_stat = rd && (addr == RA_STAT);
  assign wr_stat = wr && (addr == RA_STAT);
  assign ok_go   = en_q && !stop_q && !ovr_q;
  assign launch  = !busy && ok_go && (rd_data || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= '0;
      case (addr)
        RA_CTRL: begin
          rdata[CTRL_EN_BIT]   <= en_q;
          rdata[CTRL_STOP_BIT] <= stop_q;
        end
        RA_STAT: begin
          rdata[STAT_FULL_BIT] <= full_q;
          rdata[STAT_OVR_BIT]  <= ovr_q;
        end
        RA_DATA: rdata <= data_q;
        default: rdata <= DW'(div);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stop_q <= 1'b0;
      div    <= DIVW'(DIV_RST);
    end else if (wr) begin
      if (addr == RA_CTRL) begin
        en_q   <= wdata[CTRL_EN_BIT];
        stop_q <= wdata[CTRL_STOP_BIT];
      end
      if (addr == RA_DIV) div <= DIVW'(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (launch || !ok_go) begin
      pend_q <= 1'b0;
    end else if (rd_data && busy) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (rd_stat && ovr_q) armed_q <= 1'b1;
      if (wr_stat && !wdata[STAT_OVR_BIT] && armed_q) begin
        ovr_q   <= 1'b0;
        armed_q <= 1'b0;
      end
      if (done) begin
        if (full_q && !rd_data) begin
          ovr_q   <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          data_q <= byte_i;
          full_q <= 1'b1;
        end
      end else if (rd_data) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import rxm_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DIVW    = 8,
  parameter int DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              ser_clk,
  input  logic              ser_din
);
  logic            launch, busy, done;
  logic [DIVW-1:0] div;
  logic [DW-1:0]   rx_byte;

  rxm_regs #(.DW(DW), .DIVW(DIVW), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
    .byte_i(rx_byte), .launch(launch), .div(div)
  );

  rxm_shifter #(.DW(DW), .DIVW(DIVW)) u_shift (
    .clk(clk), .rst_n(rst_n), .launch(launch), .div(div), .sdi(ser_din),
    .sck(ser_clk), .busy(busy), .done(done), .byte_o(rx_byte)
  );
endmodule

// File: rtl/rxm_chk.sv
module rxm_chk
  import rxm_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              wr,
  input logic [DW-1:0]     wdata,
  input logic              sck,
  input logic              busy,
  input logic              done,
  input logic              en,
  input logic              stop,
  input logic              full,
  input logic              ovr
);
  logic rd_data, wr_stat;
  assign rd_data = rd && (addr == RA_DATA);
  assign wr_stat = wr && (addr == RA_STAT);

  AST_EN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!en && !busy) |=> !busy); // R2
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck); // R3
  AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) (done && !full) |=> full); // R4
  AST_RD_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rd_data && !done) |=> !full); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (stop && !busy) |=> !busy); // R7
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) (done && full && !rd_data) |=> ovr); // R9
  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (ovr && !busy) |=> !busy); // R10
  AST_W1_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (ovr && wr_stat && wdata[STAT_OVR_BIT]) |=> ovr); // R11
endmodule

bind sync_rx_master rxm_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
  .wdata(bus_wdata), .sck(ser_clk), .busy(u_shift.busy), .done(u_shift.done),
  .en(u_regs.en_q), .stop(u_regs.stop_q), .full(u_regs.full_q), .ovr(u_regs.ovr_q)
);

// File: tb/sim_sync_rx_master.sv
`timescale 1ns/1ps
module sim_sync_rx_master;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          ser_clk;
  logic          ser_din = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int falls = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sync_rx_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk(ser_clk), .ser_din(ser_din)
  );

  always @(negedge ser_clk) falls++;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // All bus tasks are entered and left at a falling clock edge.
  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic serve(input logic [DW-1:0] b);
    for (int i = 0; i < DW; i++) begin
      @(negedge ser_clk);
      ser_din = b[DW-1-i];
    end
  endtask

  task automatic settle(input int div);
    repeat (2*div + 6) @(negedge clk);
  endtask

  task automatic expect_quiet(input string req);
    int f0;
    f0 = falls;
    repeat (60) @(negedge clk);
    check(req, "no serial clock edges", falls - f0, 0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    bus_read(2'd0, d); check("R1", "control after reset", d, 0);
    bus_read(2'd1, d); check("R1", "status after reset", d, 0);
    bus_read(2'd3, d); check("R1", "divider after reset", d, 3);
    check("R1", "ser_clk idle", ser_clk, 1);
  endtask

  task automatic t_disabled();
    logic [DW-1:0] d;
    bus_read(2'd2, d);
    expect_quiet("R2");
  endtask

  task automatic t_timing();
    logic [DW-1:0] d, s0, s1;
    bus_write(2'd3, 8'd2);
    bus_write(2'd0, 8'h01);
    fork
      serve(8'hA5);
      begin
        bus_read(2'd2, d);        // dummy read, accepted at edge k
        repeat (15*3) @(negedge clk);
        bus_read(2'd1, s0);       // accepted at k+15*(div+1)+1
        bus_read(2'd1, s1);       // one cycle later
      end
    join
    check("R4", "full just before due cycle", s0[0], 0);
    check("R4", "full at due cycle", s1[0], 1);
    check("R3", "ser_clk idle after byte", ser_clk, 1);
  endtask

  task automatic t_continuous();
    logic [DW-1:0] d;
    int f0;
    f0 = falls;
    fork serve(8'h3C); bus_read(2'd2, d); join
    check("R5", "read returns first byte MSB first", d, 8'hA5);
    settle(2);
    bus_read(2'd1, d); check("R6", "full after second byte", d, 8'h01);
    fork serve(8'hC3); bus_read(2'd2, d); join
    check("R6", "read returns second byte", d, 8'h3C);
    settle(2);
    check("R3", "eight clocks per byte", falls - f0, 16);
  endtask

  task automatic t_stop();
    logic [DW-1:0] d;
    fork
      serve(8'h5A);
      begin bus_read(2'd2, d); bus_write(2'd0, 8'h03); end
    join
    check("R6", "byte before stop", d, 8'hC3);
    settle(2);
    bus_read(2'd1, d); check("R7", "in-flight byte stored", d, 8'h01);
    bus_read(2'd2, d); check("R7", "last byte value", d, 8'h5A);
    expect_quiet("R7");
  endtask

  task automatic t_finish();
    logic [DW-1:0] d;
    bus_write(2'd0, 8'h01);
    fork serve(8'h11); bus_read(2'd2, d); join
    settle(2);
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, d); check("R8", "final byte", d, 8'h11);
    expect_quiet("R8");
    bus_read(2'd1, d); check("R8", "status after finish", d, 0);
  endtask

  task automatic t_overrun();
    logic [DW-1:0] d;
    bus_write(2'd0, 8'h01);
    fork
      begin serve(8'h77); serve(8'h88); end
      begin bus_read(2'd2, d); bus_read(2'd2, d); end
    join
    settle(2);
    bus_write(2'd1, 8'h00);   // not yet read as 1: no effect
    bus_read(2'd1, d); check("R9", "full and overrun", d, 8'h03);
    check("R11", "write 0 before status read kept flag", d[1], 1);
    bus_read(2'd2, d); check("R9", "old byte kept", d, 8'h77);
    expect_quiet("R10");
    bus_write(2'd1, 8'h02);
    bus_read(2'd1, d); check("R11", "write 1 leaves overrun", d, 8'h02);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R11", "write 0 after read clears", d, 8'h00);
    fork serve(8'h99); bus_read(2'd2, d); join
    settle(2);
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, d); check("R10", "transfer resumes after clear", d, 8'h99);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_timing();
    t_continuous();
    t_stop();
    t_finish();
    t_overrun();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end
endmodule